// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This unit executes the two word-sized reservation instructions of a 32-bit RISC-V core: load-reserved and store-conditional. The pipeline hands it an instruction word with a start pulse, along with the current PC and the two source register values. The unit then makes at most one single-word access over a request/acknowledge memory port, which can report an error. One cycle later it returns a register write-back, the next PC and an exception flag.

The unit holds one reservation, made of a valid bit and an address. A load-reserved that completes without error fills the reservation. A store-conditional writes memory only when the reservation is valid and its address exactly equals the rs1 value. It returns 0 in rd on success and 1 on failure. A store-conditional that does not fault drops the reservation. A faulting access leaves both the reservation and the destination register untouched. The ordering bits in the instruction are ignored.

Top module: `lrsc_unit`

## Requirements
- R1: A word is a load-reserved when (w & 0xF9F0707F) == 0x1000202F and a store-conditional when (w & 0xF800707F) == 0x1800202F. Any other word makes no memory request and no write-back, and gives `illegal`=1 in the done cycle, which is the cycle after the start is accepted.
- R2: rd comes from bits 11:7, rs1 from bits 19:15 and rs2 from bits 24:20. Bits 26 and 25 (the ordering bits) have no effect on any output.
- R3: A load-reserved reads the word at the rs1 value (`mem_we`=0). If the read is error-free, it writes the returned word to rd and sets the reservation to that address.
- R4: A load-reserved whose read returns an error raises `exc`, writes no register and leaves the reservation as it was.
- R5: A store-conditional writes the rs2 value to the rs1 address (`mem_we`=1) only when the reservation is valid and its address equals the rs1 value exactly. Otherwise it makes no memory request and finishes in the cycle after acceptance.
- R6: A store-conditional writes 0 to rd when its store was performed and 1 when the store was skipped.
- R7: A store-conditional that does not fault invalidates the reservation, whether it succeeded or failed.
- R8: A store-conditional whose write returns an error raises `exc`, writes no register and keeps the reservation.
- R9: `wb_en` is never raised for rd = 0. In every done cycle, `next_pc` equals the accepted `pc` plus 4.
- R10: Reset clears the reservation, so a store-conditional issued before any load-reserved fails with rd = 1.
- R11: `start` is accepted only while `ready`=1. `mem_req`, `mem_addr`, `mem_wdata`, `mem_we` and `mem_be` (all four bytes) stay stable until `mem_ack`. `done` pulses for one cycle, in the cycle after `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction valid, taken while ready |
| instr | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction |
| rs1_val | input | 32 | Value of source register rs1 (address) |
| rs2_val | input | 32 | Value of source register rs2 (store data) |
| ready | output | 1 | Unit idle, can take a start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, all set during a request |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Access error, valid with ack |
| mem_rdata | input | 32 | Read data, valid with ack |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | Register write enable, valid with done |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Write-back value |
| next_pc | output | 32 | PC + 4 |
| exc | output | 1 | Access fault, valid with done |
| illegal | output | 1 | Unrecognised instruction, valid with done |

## Verification
When an instruction needs no memory access (an illegal word or a failed store-conditional), `done` and its results are due in the cycle right after the accepting edge. The bench samples them at the first falling edge after that edge, and it also checks there that no request was raised. When an access is made, the request must already be visible at that same falling edge. The bench drives the acknowledge after a random number of wait cycles and expects `done` with its results at the falling edge that follows the acknowledging edge. An independent reservation and memory model in the bench supplies the expected values.

// File: rtl/lrsc_unit.sv
module lrsc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] instr,
  input  logic [31:0] pc,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic        ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic        wb_en,
  output logic [4:0]  wb_idx,
  output logic [31:0] wb_data,
  output logic [31:0] next_pc,
  output logic        exc,
  output logic        illegal
);

  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} state_t;
  state_t state;

  logic        resv_ok;
  logic [31:0] resv_addr;
  logic        op_load;
  logic        wb_q, exc_q, ill_q;
  logic [4:0]  rd_q;

  wire is_load  = (instr & 32'hF9F0707F) == 32'h1000202F;
  wire is_store = (instr & 32'hF800707F) == 32'h1800202F;
  wire [4:0] rd_f = instr[11:7];
  wire hit      = resv_ok && (resv_addr == rs1_val);
  wire accept   = start && (state == ST_IDLE);

  assign ready   = state == ST_IDLE;
  assign mem_req = state == ST_MEM;
  assign mem_be  = {4{mem_req}};
  assign done    = state == ST_DONE;
  assign wb_en   = done && wb_q;
  assign exc     = done && exc_q;
  assign illegal = done && ill_q;
  assign wb_idx  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      resv_ok   <= 1'b0;
      resv_addr <= '0;
      op_load   <= 1'b0;
      wb_q      <= 1'b0;
      exc_q     <= 1'b0;
      ill_q     <= 1'b0;
      rd_q      <= '0;
      wb_data   <= '0;
      next_pc   <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          next_pc   <= pc + 32'd4;
          rd_q      <= rd_f;
          mem_addr  <= rs1_val;
          mem_wdata <= rs2_val;
          op_load   <= is_load;
          mem_we    <= is_store;
          wb_q      <= 1'b0;
          exc_q     <= 1'b0;
          ill_q     <= 1'b0;
          wb_data   <= '0;
          if (is_load || (is_store && hit)) begin
            state <= ST_MEM;
          end else if (is_store) begin
            resv_ok <= 1'b0;
            wb_q    <= rd_f != 5'd0;
            wb_data <= 32'd1;
            state   <= ST_DONE;
          end else begin
            ill_q <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_MEM: if (mem_ack) begin
          state <= ST_DONE;
          if (mem_err) begin
            exc_q <= 1'b1;
          end else if (op_load) begin
            resv_ok   <= 1'b1;
            resv_addr <= mem_addr;
            wb_q      <= rd_q != 5'd0;
            wb_data   <= mem_rdata;
          end else begin
            resv_ok <= 1'b0;
            wb_q    <= rd_q != 5'd0;
            wb_data <= 32'd0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));
  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && ready);
  a_r9_no_x0: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != 5'd0);
  a_r4_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> !wb_en && !illegal);
  a_r1_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en && !exc);
  a_r8_store_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> $stable(resv_ok) && $stable(resv_addr));

endmodule

// File: tb/tb_lrsc_unit.sv
module tb_lrsc_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic start = 0;
  logic [31:0] instr = 0, pc = 0, rs1_val = 0, rs2_val = 0;
  logic ready, mem_req, mem_we, done, wb_en, exc, illegal;
  logic [31:0] mem_addr, mem_wdata, wb_data, next_pc;
  logic [3:0] mem_be;
  logic [4:0] wb_idx;
  logic mem_ack = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:15];
  bit m_ok = 0;
  logic [31:0] m_addr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_unit dut (.*);

  function automatic bit f_load(input logic [31:0] w);
    return (w & 32'hF9F0707F) == 32'h1000202F;
  endfunction
  function automatic bit f_store(input logic [31:0] w);
    return (w & 32'hF800707F) == 32'h1800202F;
  endfunction
  function automatic logic [31:0] mk_lr(input logic [4:0] rd, input bit aq, input bit rl);
    return {5'b00010, aq, rl, 5'd0, 5'd7, 3'b010, rd, 7'h2F};
  endfunction
  function automatic logic [31:0] mk_sc(input logic [4:0] rd, input bit aq, input bit rl);
    return {5'b00011, aq, rl, 5'd9, 5'd7, 3'b010, rd, 7'h2F};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_op(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] pcv, input bit inj_err, input int lat);
    bit ld = f_load(w), st = f_store(w);
    bit hit = m_ok && (m_addr == a);
    bit use_mem = ld || (st && hit);
    logic [4:0] rd = w[11:7];
    bit e_wb = 0, e_exc = 0;
    logic [31:0] e_data = 0;
    string rq = ld ? "R3" : (st ? "R5" : "R1");
    @(negedge clk);
    chk(ready === 1'b1, "R11", "ready before start", {31'd0, ready}, 1);
    instr = w; rs1_val = a; rs2_val = b; pc = pcv; start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk(mem_req === use_mem, rq, "request presence", {31'd0, mem_req}, {31'd0, use_mem});
    if (use_mem) begin
      chk(mem_addr === a && mem_we === st && mem_be === 4'hF, rq, "addr/we/be",
          mem_addr, a);
      if (st) chk(mem_wdata === b, "R5", "store data", mem_wdata, b);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(mem_req === 1'b1 && mem_addr === a, "R11", "held request", mem_addr, a);
      end
      mem_ack = 1; mem_err = inj_err; mem_rdata = mem[a[5:2]];
      @(negedge clk);
      mem_ack = 0; mem_err = 0; mem_rdata = 0;
      if (inj_err) e_exc = 1;
      else if (ld) begin
        e_wb = rd != 0; e_data = mem[a[5:2]]; m_ok = 1; m_addr = a;
      end else begin
        e_wb = rd != 0; e_data = 0; m_ok = 0; mem[a[5:2]] = b;
      end
    end else if (st) begin
      e_wb = rd != 0; e_data = 1; m_ok = 0;
    end
    chk(done === 1'b1, rq, "done timing", {31'd0, done}, 1);
    chk(illegal === !(ld || st), "R1", "illegal flag", {31'd0, illegal}, {31'd0, !(ld || st)});
    chk(exc === e_exc, ld ? "R4" : "R8", "exc", {31'd0, exc}, {31'd0, e_exc});
    chk(wb_en === e_wb, st ? "R6" : "R9", "wb_en", {31'd0, wb_en}, {31'd0, e_wb});
    if (e_wb) chk(wb_idx === rd && wb_data === e_data, st ? "R6" : "R3", "wb data",
                  wb_data, e_data);
    chk(next_pc === pcv + 32'd4, "R9", "next_pc", next_pc, pcv + 32'd4);
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk(ready === 1 && done === 0 && mem_req === 0, "R11", "reset state",
        {29'd0, ready, done, mem_req}, 32'h4);
    rst_n = 1;
    // R10: store-conditional right after reset fails
    run_op(mk_sc(5'd3, 0, 0), 32'h100, 32'hAAAA0001, 32'h1000, 0, 0);
    // R3/R6/R7: reserve then succeed, then fail
    run_op(mk_lr(5'd4, 0, 0), 32'h104, 0, 32'h1004, 0, 2);
    run_op(mk_sc(5'd5, 0, 0), 32'h104, 32'h5555AAAA, 32'h1008, 0, 1);
    run_op(mk_lr(5'd6, 0, 0), 32'h104, 0, 32'h100C, 0, 0);
    chk(mem[1] === 32'h5555AAAA, "R5", "stored word read back", mem[1], 32'h5555AAAA);
    run_op(mk_sc(5'd5, 0, 0), 32'h108, 32'h1, 32'h1010, 0, 0);
    run_op(mk_sc(5'd5, 0, 0), 32'h104, 32'h1, 32'h1014, 0, 0);
    // R4: faulting load keeps previous reservation
    run_op(mk_lr(5'd7, 1, 1), 32'h10C, 0, 32'h1018, 0, 0);
    run_op(mk_lr(5'd8, 0, 0), 32'h100, 0, 32'h101C, 1, 3);
    run_op(mk_sc(5'd9, 1, 0), 32'h10C, 32'h77, 32'h1020, 0, 0);
    // R8: faulting store keeps reservation, retry succeeds
    run_op(mk_lr(5'd10, 0, 1), 32'h110, 0, 32'h1024, 0, 0);
    run_op(mk_sc(5'd11, 0, 0), 32'h110, 32'h99, 32'h1028, 1, 1);
    run_op(mk_sc(5'd0, 0, 0), 32'h110, 32'h98, 32'h102C, 0, 0);
    // R9: rd = 0 writes nothing
    run_op(mk_lr(5'd0, 0, 0), 32'h114, 0, 32'h1030, 0, 0);
    // R1: illegal words, incl. load with nonzero rs2 field
    run_op(mk_lr(5'd1, 0, 0) | (32'd3 << 20), 32'h114, 0, 32'h1034, 0, 0);
    run_op(32'h00000013, 32'h114, 0, 32'h1038, 0, 0);
    // R2: random mix, ordering bits random
    for (int n = 0; n < 400; n++) begin
      int k = $urandom_range(0, 11);
      logic [4:0] rd = 5'($urandom_range(0, 31));
      bit aq = 1'($urandom), rl = 1'($urandom);
      logic [31:0] a = 32'h100 + 32'($urandom_range(0, 3)) * 4;
      logic [31:0] w;
      if (k < 5) w = mk_lr(rd, aq, rl);
      else if (k < 10) begin
        w = mk_sc(rd, aq, rl);
        if (m_ok && $urandom_range(0, 1)) a = m_addr;
      end else if (k == 10) w = $urandom;
      else w = mk_lr(rd, aq, rl) | (32'($urandom_range(1, 31)) << 20);
      run_op(w, a, $urandom, 32'($urandom) & ~32'h3, $urandom_range(0, 7) == 0,
             $urandom_range(0, 4));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule